// File: doc/BRIEF.md
# Monochrome Scanline Fetcher and Pixel Serializer

This block turns a one-bit-per-pixel frame buffer into a serial pixel stream for a raster display. At the start of every visible line it reads a fixed number of 32-bit words from a synchronous memory read port. It then sends their bits out one per pixel-enable strobe, starting with the most significant bit of each word. Whenever no image pixel is due, including pixels past the end of the active span and whole lines marked not visible, the pixel output is driven to zero.

The start address of each line moves forward by one line's worth of bytes. After a set number of visible lines, the address jumps to the base of a second memory region, so the picture can be stored in two separate areas. A frame-start pulse sends the address back to the base of the first region.

The line-start, frame-start, visible-line and pixel-enable inputs come from an external display timing generator. The block holds a two-word buffer. While one word is being shifted out, the next is already fetched, so back-to-back pixel strobes see no gap at word boundaries.

Top module: `mono_line_fetch`

## Requirements
- R1: During reset and on the first cycle after reset, `pix_out` is 0 and `mem_rd` is 0.
- R2: On each visible line the block makes exactly `LINE_WORDS` reads. Each read address is a multiple of 4 bytes, and read k of the line uses the line base plus 4·k.
- R3: Pixel n of a visible line is bit 31−(n mod 32) of the n/32-th word of that line, so each word goes out most significant bit first. One pixel is delivered for each `pix_en` strobe, and it appears on `pix_out` in the cycle after the strobe.
- R4: Each visible line moves the line base forward by `LINE_WORDS`·4 bytes. A line with `line_visible` low leaves the line base and the visible-line count unchanged.
- R5: After `SWITCH_LINE` visible lines have been fetched in a frame, the next line's base is `BASE_B`. Later lines step forward from `BASE_B` by the same stride.
- R6: `frame_start` reloads the line base with `BASE_A` and clears the visible-line count. If it comes in the same cycle as `line_start`, that line is fetched from `BASE_A`, and its first read is issued in the cycle after.
- R7: `pix_en` strobes after the first `LINE_WORDS`·32 strobes of a visible line produce 0 on `pix_out`.
- R8: On a line with `line_visible` low, `pix_out` is 0 on every strobe and no memory read is issued.
- R9: `pix_out` changes only in the cycle after a `pix_en` strobe. Between strobes it holds its value.
- R10: With memory read latency of one cycle and the first strobe no earlier than the third cycle after `line_start`, the output is correct even when `pix_en` is high on every cycle. This includes the word boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that marks the start of a frame |
| line_start | input | 1 | One-cycle pulse that marks the start of a line |
| line_visible | input | 1 | High while the current line carries image data; sampled with `line_start` |
| pix_en | input | 1 | Pixel strobe; one pixel is consumed per high cycle |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| pix_out | output | 1 | Serial pixel output |

## Verification
Full frames are swept with pixel strobes on every cycle, on every second cycle and on every fourth cycle. The every-cycle case shows whether the prefetch keeps up across word boundaries. The sparse cases show whether the output holds between strobes. Each frame runs enough visible lines to cross the region switch, and one frame has a blank line inserted mid-frame, which shows whether the base advances on visible lines only. A frame cut short by an early frame-start shows whether the base goes back to the first region. Strobes past the active span, and whole blank lines, are expected to give zeros and no reads.

// File: rtl/mono_line_fetch.sv
module mono_line_fetch #(
  parameter int ADDR_W = 32,
  parameter int LINE_WORDS = 20,
  parameter int SWITCH_LINE = 400,
  parameter logic [ADDR_W-1:0] BASE_A = '0,
  parameter logic [ADDR_W-1:0] BASE_B = ADDR_W'(32'h0001_0000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              line_visible,
  input  logic              pix_en,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              pix_out
);
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;
  localparam int STRIDE = LINE_WORDS * BYTES;
  localparam int PIX    = LINE_WORDS * WORD_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int PIX_W  = $clog2(PIX + 1);
  localparam int WC_W   = $clog2(LINE_WORDS + 1);
  localparam int LC_W   = $clog2(SWITCH_LINE + 1);

  logic              active, sh_v, nx_v, pend;
  logic [ADDR_W-1:0] line_ptr, rd_ptr;
  logic [LC_W-1:0]   line_cnt;
  logic [WC_W-1:0]   req_cnt;
  logic [PIX_W-1:0]  left;
  logic [BIT_W-1:0]  bcnt;
  logic [WORD_W-1:0] sh, nx;

  wire take = pix_en & active & (left != '0);
  wire last = take & (bcnt == BIT_W'(WORD_W - 1));
  wire room = !((sh_v & nx_v) | (sh_v & pend) | (nx_v & pend));
  wire [ADDR_W-1:0] base_now = frame_start ? BASE_A : line_ptr;
  wire [LC_W-1:0]   cnt_now  = frame_start ? '0 : line_cnt;

  assign mem_rd   = active & (req_cnt != WC_W'(LINE_WORDS)) & room;
  assign mem_addr = rd_ptr + ADDR_W'(req_cnt) * ADDR_W'(BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_ptr <= BASE_A;
      line_cnt <= '0;
      rd_ptr   <= BASE_A;
      active   <= 1'b0;
    end else if (line_start) begin
      if (line_visible) begin
        rd_ptr   <= base_now;
        active   <= 1'b1;
        line_ptr <= (cnt_now == LC_W'(SWITCH_LINE - 1)) ? BASE_B
                                                         : base_now + ADDR_W'(STRIDE);
        line_cnt <= (cnt_now == LC_W'(SWITCH_LINE)) ? cnt_now : cnt_now + 1'b1;
      end else begin
        active   <= 1'b0;
        line_ptr <= base_now;
        line_cnt <= cnt_now;
      end
    end else if (frame_start) begin
      line_ptr <= BASE_A;
      line_cnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v <= 1'b0; nx_v <= 1'b0; pend <= 1'b0;
      sh <= '0; nx <= '0;
      bcnt <= '0; left <= '0; req_cnt <= '0;
    end else begin
      pend <= mem_rd & ~line_start;
      if (line_start) begin
        sh_v    <= 1'b0;
        nx_v    <= 1'b0;
        bcnt    <= '0;
        req_cnt <= '0;
        left    <= line_visible ? PIX_W'(PIX) : '0;
      end else begin
        if (mem_rd) req_cnt <= req_cnt + 1'b1;
        if (take) begin
          left <= left - 1'b1;
          bcnt <= bcnt + 1'b1;
        end
        if (last) begin
          if (nx_v) begin
            sh <= nx;
            sh_v <= 1'b1;
            if (pend) nx <= mem_rdata;
            else nx_v <= 1'b0;
          end else if (pend) begin
            sh <= mem_rdata;
            sh_v <= 1'b1;
          end else begin
            sh_v <= 1'b0;
          end
        end else begin
          if (take) sh <= sh << 1;
          if (pend) begin
            if (!sh_v) begin
              sh <= mem_rdata;
              sh_v <= 1'b1;
            end else begin
              nx <= mem_rdata;
              nx_v <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_out <= 1'b0;
    else if (pix_en) pix_out <= take & sh[WORD_W-1];
  end
endmodule

// File: rtl/mono_line_fetch_chk.sv
module mono_line_fetch_chk #(
  parameter int ADDR_W = 32,
  parameter int PIX_W = 8,
  parameter logic [ADDR_W-1:0] BASE_A = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              line_visible,
  input logic              pix_en,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pix_out,
  input logic [PIX_W-1:0]  left
);
  // R9
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(pix_out));

  // R8
  blank_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start && !line_visible |=> !mem_rd);

  // R6
  frame_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && line_start && line_visible |=> mem_rd && mem_addr == BASE_A);

  // R7
  past_span_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !line_start && left == '0 |=> !pix_out);

  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'b00);
endmodule

bind mono_line_fetch mono_line_fetch_chk #(
  .ADDR_W(ADDR_W), .PIX_W(PIX_W), .BASE_A(BASE_A)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .line_visible(line_visible), .pix_en(pix_en), .mem_rd(mem_rd),
  .mem_addr(mem_addr), .pix_out(pix_out), .left(left)
);

// File: tb/mono_line_fetch_test.sv
module mono_line_fetch_test;
  localparam int W  = 2;
  localparam int SW = 3;
  localparam int PIX = W * 32;
  localparam logic [31:0] BA = 32'h40;
  localparam logic [31:0] BB = 32'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, line_start = 0, line_visible = 0, pix_en = 0;
  logic mem_rd, pix_out;
  logic [31:0] mem_addr, mem_rdata;
  logic [31:0] mem [0:127];
  int checks = 0, fails = 0;
  int rd_cnt = 0;
  logic [31:0] rd_log [0:7];
  bit done = 0;

  always #2 clk = ~clk;

  mono_line_fetch #(.ADDR_W(32), .LINE_WORDS(W), .SWITCH_LINE(SW),
                    .BASE_A(BA), .BASE_B(BB)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .line_visible(line_visible), .pix_en(pix_en), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pix_out(pix_out));

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[8:2]];
    if (mem_rd) begin
      if (rd_cnt < 8) rd_log[rd_cnt] = mem_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input bit ls, input bit fs, input bit pe);
    line_start = ls; frame_start = fs; pix_en = pe;
    @(posedge clk); #1;
    line_start = 0; frame_start = 0; pix_en = 0;
  endtask

  function automatic logic [31:0] line_base(input int l);
    return (l < SW) ? BA + 32'(l * W * 4) : BB + 32'(((l - SW) * W * 4));
  endfunction

  task automatic do_line(input bit fs, input bit vis, input int l, input int gap);
    logic [31:0] b = line_base(l);
    logic expb, prev;
    line_visible = vis;
    rd_cnt = 0;
    tick(1, fs, 0);
    tick(0, 0, 0);
    tick(0, 0, 0);
    for (int p = 0; p < PIX + 8; p++) begin
      tick(0, 0, 1);
      expb = 1'b0;
      if (vis && p < PIX) expb = mem[(b >> 2) + 32'(p / 32)][31 - (p % 32)];
      if (!vis) check("R8 blank line pixel", {31'b0, pix_out}, 0);
      else if (p >= PIX) check("R7 past span", {31'b0, pix_out}, 0);
      else if (gap == 0) check("R10 R3 pixel", {31'b0, pix_out}, {31'b0, expb});
      else check("R3 pixel", {31'b0, pix_out}, {31'b0, expb});
      for (int g = 0; g < gap; g++) begin
        prev = pix_out;
        tick(0, 0, 0);
        check("R9 hold", {31'b0, pix_out}, {31'b0, prev});
      end
    end
    if (vis) begin
      check("R2 read count", rd_cnt, W);
      for (int k = 0; k < W; k++)
        check(l < SW ? "R2 R4 R6 read addr" : "R5 read addr", rd_log[k], b + 32'(4 * k));
    end else begin
      check("R8 no reads", rd_cnt, 0);
    end
  endtask

  task automatic frame(input int gap, input int nlines, input bit blank_mid);
    for (int l = 0; l < nlines; l++) begin
      if (blank_mid && l == 2) do_line(0, 0, 0, gap);
      do_line(l == 0, 1, l, gap);
    end
    do_line(0, 0, 0, gap);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i << 7);
    repeat (3) @(posedge clk);
    #1;
    check("R1 pix_out in reset", {31'b0, pix_out}, 0);
    check("R1 mem_rd in reset", {31'b0, mem_rd}, 0);
    rst_n = 1'b1;
    tick(0, 0, 0);
    check("R1 pix_out after reset", {31'b0, pix_out}, 0);
    check("R1 mem_rd after reset", {31'b0, mem_rd}, 0);
    frame(0, SW + 3, 0);
    frame(1, 2, 0);
    frame(1, SW + 3, 1);
    frame(3, SW + 3, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule